// File: doc/BRIEF.md
# Multiplexed LCD Segment Scan Controller

This block scans a multiplexed segment LCD with 40 segment lines and 4 common lines. A CPU writes a 20-byte display memory over a simple address, data and strobe port. Each byte carries two segments, one per nibble, and each nibble holds one bit per common line. A control strobe loads three values: the enable bit, a 2-bit duty code and an 8-bit divider value. The divider value N sets the length of each common phase in clocks.

While the display is running, the block steps through the active common phases in order. In each phase it drives one common line as selected and the other driven commons as unselected. Each segment line is driven from the memory bit that belongs to it and to the current phase. An AC polarity bit flips after every complete frame, which lets an external analog stage cancel the DC component of the drive. All outputs are 2-bit level codes that the external analog driver turns into bias voltages.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset, every common and segment level code is 0 (idle) and `ac_pol` is 0.
- R2: When the enable bit is 0, or the duty code is 00, every common and segment code is 0 (idle) and `ac_pol` is 0.
- R3: Duty code 01 drives COM0..COM1, code 10 drives COM0..COM2, and code 11 drives COM0..COM3. A common that the duty code leaves undriven shows code 3 (open). Common i occupies bits [2i+1:2i] of `com_lvl`.
- R4: In active phase p, common p shows code 1 (selected) and every other driven common shows code 2 (unselected).
- R5: Address 0x40+k holds segment 2k in bits [3:0] and segment 2k+1 in bits [7:4]. Bit p of a nibble belongs to phase p. In phase p a segment shows code 1 when its bit is 1 and code 2 when its bit is 0. Segment j occupies bits [2j+1:2j] of `seg_lvl`.
- R6: Each phase lasts exactly N clocks, where N is the divider value; N=0 behaves as N=1.
- R7: Phases run 0,1,...,active-1 and then wrap to 0. `ac_pol` inverts at every wrap.
- R8: A control strobe restarts the scan. One clock after the strobe, the outputs show phase 0 with `ac_pol` at 0, and the phase timing counts from the strobe.
- R9: Writes to addresses outside 0x40..0x53 change no segment output.
- R10: Data written during a phase does not change the outputs of that phase. It appears from the next phase boundary on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which is also the divider count source |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | 8 | Display memory byte address |
| wr_data | input | 8 | Display memory write data |
| ctl_we | input | 1 | Control load strobe; also restarts the scan |
| ctl_en | input | 1 | Display enable |
| ctl_duty | input | 2 | Duty code (00 off, 01 two, 10 three, 11 four commons) |
| ctl_div | input | 8 | Phase length in clocks |
| com_lvl | output | 8 | Common level codes, 2 bits per common |
| seg_lvl | output | 80 | Segment level codes, 2 bits per segment |
| ac_pol | output | 1 | Drive polarity |

## Verification
The control strobe is registered at edge E and the output registers sit one stage behind the phase state. Phase p is therefore visible from edge E+1+p·L until edge E+1+(p+1)·L, where L is N, or 1 when N=0. The bench samples on the falling edge right after E+1+p·L and computes the expected codes from its own copy of the memory, from the phase index and from the frame parity.

A memory write committed at any edge inside a phase is checked twice. It is checked before the boundary against the old contents, and then after the boundary against the new contents. Duty and divider are swept over all three duties and several N values, including 0 and 1.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [1:0] {
    LVL_IDLE  = 2'd0,
    LVL_SEL   = 2'd1,
    LVL_UNSEL = 2'd2,
    LVL_OPEN  = 2'd3
  } lcd_lvl_e;
endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             active,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim_m1;

  assign lim_m1 = (div_val == '0) ? '0 : div_val - 1'b1;
  assign tick   = active && !restart && (cnt >= lim_m1);

  always_ff @(posedge clk) begin
    if (rst || restart || !active) cnt <= '0;
    else if (cnt >= lim_m1)        cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    active |-> cnt <= lim_m1);
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq #(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            tick,
  input  logic [PH_W-1:0] ncom_m1,
  output logic [PH_W-1:0] phase_q,
  output logic [PH_W-1:0] phase_nxt,
  output logic            ac_q,
  output logic            load
);
  logic wrap;

  assign wrap = (phase_q >= ncom_m1);
  assign load = restart || tick;

  always_comb begin
    if (restart)   phase_nxt = '0;
    else if (tick) phase_nxt = wrap ? '0 : phase_q + 1'b1;
    else           phase_nxt = phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      ac_q    <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      if (restart)          ac_q <= 1'b0;
      else if (tick && wrap) ac_q <= ~ac_q;
    end
  end

  a_r7_phase_bound: assert property (@(posedge clk) disable iff (rst)
    phase_q <= ncom_m1 || ncom_m1 == '0);
  a_r7_ac_flip: assert property (@(posedge clk) disable iff (rst)
    (tick && wrap && !restart) |=> ac_q != $past(ac_q));
endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BASE_ADDR = 'h40,
  parameter int NUM_SEG   = 40,
  parameter int NUM_COM   = 4,
  parameter int PH_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [PH_W-1:0]   rd_phase,
  output logic [NUM_SEG-1:0] row
);
  localparam int SPB   = DATA_W / NUM_COM;
  localparam int BYTES = NUM_SEG / SPB;
  localparam int IDX_W = $clog2(BYTES);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE_ADDR + BYTES);

  logic [DATA_W-1:0] mem [BYTES];
  logic              in_range;
  logic [NUM_SEG-1:0] row_d;

  assign in_range = (addr >= BASE_A) && (addr < END_A);

  always_ff @(posedge clk) begin
    if (we && in_range) mem[IDX_W'(addr - BASE_A)] <= wdata;
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    logic [NUM_COM-1:0] nib;
    assign nib      = mem[j / SPB][(j % SPB) * NUM_COM +: NUM_COM];
    assign row_d[j] = nib[rd_phase];
  end

  always_ff @(posedge clk) begin
    if (rst)        row <= '0;
    else if (rd_en) row <= row_d;
  end

  a_r10_row_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(row));
endmodule

// File: rtl/lcd_level_drive.sv
module lcd_level_drive
  import lcd_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 40,
  parameter int PH_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   active,
  input  logic [PH_W-1:0]        ncom_m1,
  input  logic [PH_W-1:0]        phase,
  input  logic [NUM_SEG-1:0]     row,
  input  logic                   ac,
  output logic [2*NUM_COM-1:0]   com_lvl,
  output logic [2*NUM_SEG-1:0]   seg_lvl,
  output logic                   ac_pol
);
  logic [2*NUM_COM-1:0] com_d;
  logic [2*NUM_SEG-1:0] seg_d;

  always_comb begin
    for (int i = 0; i < NUM_COM; i++) begin
      if (!active)                  com_d[2*i +: 2] = LVL_IDLE;
      else if (PH_W'(i) > ncom_m1)  com_d[2*i +: 2] = LVL_OPEN;
      else if (PH_W'(i) == phase)   com_d[2*i +: 2] = LVL_SEL;
      else                          com_d[2*i +: 2] = LVL_UNSEL;
    end
    for (int j = 0; j < NUM_SEG; j++) begin
      if (!active)    seg_d[2*j +: 2] = LVL_IDLE;
      else if (row[j]) seg_d[2*j +: 2] = LVL_SEL;
      else            seg_d[2*j +: 2] = LVL_UNSEL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl <= '0;
      seg_lvl <= '0;
      ac_pol  <= 1'b0;
    end else begin
      com_lvl <= com_d;
      seg_lvl <= seg_d;
      ac_pol  <= active && ac;
    end
  end

  logic [NUM_COM-1:0] sel_chk;
  for (genvar i = 0; i < NUM_COM; i++) begin : g_chk
    assign sel_chk[i] = (com_lvl[2*i +: 2] == LVL_SEL);
    a_r3_open_unused: assert property (@(posedge clk) disable iff (rst)
      ($past(active) && (PH_W'(i) > $past(ncom_m1))) |-> com_lvl[2*i +: 2] == LVL_OPEN);
  end

  a_r4_one_selected: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_chk) <= 1);
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !$past(active) |-> (com_lvl == '0 && seg_lvl == '0 && !ac_pol));
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int NUM_SEG   = 40,
  parameter int NUM_COM   = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int BASE_ADDR = 'h40,
  localparam int PH_W     = $clog2(NUM_COM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 ctl_we,
  input  logic                 ctl_en,
  input  logic [PH_W-1:0]      ctl_duty,
  input  logic [DIV_W-1:0]     ctl_div,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic                 ac_pol
);
  logic             en_q;
  logic [PH_W-1:0]  duty_q;
  logic [DIV_W-1:0] div_q;
  logic             active;
  logic             tick;
  logic             load;
  logic [PH_W-1:0]  phase_q;
  logic [PH_W-1:0]  phase_nxt;
  logic             ac_q;
  logic [NUM_SEG-1:0] row;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      duty_q <= '0;
      div_q  <= '0;
    end else if (ctl_we) begin
      en_q   <= ctl_en;
      duty_q <= ctl_duty;
      div_q  <= ctl_div;
    end
  end

  assign active = en_q && (duty_q != '0);

  lcd_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .restart(ctl_we), .active(active),
    .div_val(div_q), .tick(tick)
  );

  lcd_phase_seq #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .restart(ctl_we), .tick(tick), .ncom_m1(duty_q),
    .phase_q(phase_q), .phase_nxt(phase_nxt), .ac_q(ac_q), .load(load)
  );

  lcd_disp_ram #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
    .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .PH_W(PH_W)
  ) u_ram (
    .clk(clk), .rst(rst), .we(wr_en), .addr(wr_addr), .wdata(wr_data),
    .rd_en(load), .rd_phase(phase_nxt), .row(row)
  );

  lcd_level_drive #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .PH_W(PH_W)) u_drive (
    .clk(clk), .rst(rst), .active(active), .ncom_m1(duty_q), .phase(phase_q),
    .row(row), .ac(ac_q), .com_lvl(com_lvl), .seg_lvl(seg_lvl), .ac_pol(ac_pol)
  );

  a_r8_restart_phase0: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (phase_q == '0 && !ac_q));
endmodule

// File: tb/lcd_scan_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_scan_ctrl_tb;
  localparam int NS = 40;
  localparam int NC = 4;
  localparam int NB = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic ctl_we = 1'b0;
  logic ctl_en = 1'b0;
  logic [1:0] ctl_duty = '0;
  logic [7:0] ctl_div = '0;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;
  logic ac_pol;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [NB];

  always #2.5 clk = ~clk;

  lcd_scan_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_duty(ctl_duty), .ctl_div(ctl_div),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .ac_pol(ac_pol)
  );

  function automatic logic [2*NC-1:0] exp_com(bit act, int nm1, int ph);
    logic [2*NC-1:0] v;
    for (int i = 0; i < NC; i++) begin
      if (!act)         v[2*i +: 2] = 2'd0;
      else if (i > nm1) v[2*i +: 2] = 2'd3;
      else if (i == ph) v[2*i +: 2] = 2'd1;
      else              v[2*i +: 2] = 2'd2;
    end
    return v;
  endfunction

  function automatic logic [2*NS-1:0] exp_seg(bit act, int ph);
    logic [2*NS-1:0] v;
    for (int j = 0; j < NS; j++) begin
      if (!act)                         v[2*j +: 2] = 2'd0;
      else if (model[j/2][(j%2)*4 + ph]) v[2*j +: 2] = 2'd1;
      else                              v[2*j +: 2] = 2'd2;
    end
    return v;
  endfunction

  task automatic check_state(string req, bit act, int nm1, int ph, bit ac);
    logic [2*NC-1:0] ec;
    logic [2*NS-1:0] es;
    ec = exp_com(act, nm1, ph);
    es = exp_seg(act, ph);
    n_tests += 3;
    if (com_lvl !== ec) begin
      n_fail++;
      $display("FAIL %s com_lvl phase %0d: actual %h expected %h", req, ph, com_lvl, ec);
    end
    if (seg_lvl !== es) begin
      n_fail++;
      $display("FAIL %s seg_lvl phase %0d: actual %h expected %h", req, ph, seg_lvl, es);
    end
    if (ac_pol !== (act && ac)) begin
      n_fail++;
      $display("FAIL %s ac_pol phase %0d: actual %0b expected %0b", req, ph, ac_pol, act && ac);
    end
  endtask

  task automatic mem_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 8'h40 && a <= 8'h53) model[a - 8'h40] = d;
  endtask

  // Control strobe committed at edge E; returns at the falling edge after E.
  task automatic ctl(bit en, logic [1:0] duty, logic [7:0] div);
    @(negedge clk);
    ctl_we = 1'b1; ctl_en = en; ctl_duty = duty; ctl_div = div;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // Phase p is visible after edge E+1+p*L; sample on the following falling edge.
  task automatic scan(string req, int duty, int div, int nph);
    int len;
    len = (div == 0) ? 1 : div;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < nph; k++) begin
      if (k > 0) begin
        repeat (len) @(posedge clk);
        @(negedge clk);
      end
      check_state(req, 1'b1, duty, k % (duty + 1), ((k / (duty + 1)) % 2) == 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_state("R1", 1'b0, 0, 0, 1'b0);

    // Fill memory, then check the display stays idle while off (R2)
    for (int i = 0; i < NB; i++) mem_wr(8'h40 + 8'(i), 8'(i * 29 + 8'h3C));
    ctl(1'b1, 2'b00, 8'd3);
    @(posedge clk); @(negedge clk);
    check_state("R2 duty00", 1'b0, 0, 0, 1'b0);
    repeat (7) @(negedge clk);
    check_state("R2 duty00 later", 1'b0, 0, 0, 1'b0);
    ctl(1'b0, 2'b11, 8'd2);
    @(posedge clk); @(negedge clk);
    check_state("R2 disabled", 1'b0, 0, 0, 1'b0);
    repeat (5) @(negedge clk);
    check_state("R2 disabled later", 1'b0, 0, 0, 1'b0);

    // Sweep over duty and divider (R3 R4 R5 R6 R7 R8)
    for (int d = 1; d <= 3; d++) begin
      for (int q = 0; q < 4; q++) begin
        int dv;
        dv = (q == 0) ? 0 : (q == 1) ? 1 : (q == 2) ? 3 : 5;
        for (int i = 0; i < NB; i++)
          mem_wr(8'h40 + 8'(i), 8'((i * 37 + d * 11 + dv * 5 + 8'h5A) ^ (i << 3)));
        ctl(1'b1, 2'(d), 8'(dv));
        scan("R3/R4/R5/R6/R7 sweep", d, dv, 2 * (d + 1) + 1);
      end
    end

    // R8: restart in mid-frame returns to phase 0 with polarity 0
    ctl(1'b1, 2'b11, 8'd2);
    repeat (9) @(posedge clk);
    ctl(1'b1, 2'b10, 8'd2);
    scan("R8 restart", 2, 2, 4);

    // R9: out-of-range writes leave the outputs as the model predicts
    ctl(1'b0, 2'b11, 8'd1);
    mem_wr(8'h3F, 8'hFF);
    mem_wr(8'h54, 8'hFF);
    mem_wr(8'hFF, 8'hFF);
    mem_wr(8'h00, 8'hA5);
    ctl(1'b1, 2'b11, 8'd1);
    scan("R9 ignored writes", 3, 1, 8);

    // R10: a write inside a phase shows only after the boundary
    for (int i = 0; i < NB; i++) mem_wr(8'h40 + 8'(i), 8'h00);
    ctl(1'b1, 2'b11, 8'd4);
    @(posedge clk); @(negedge clk);           // window after E+1
    check_state("R10 before write", 1'b1, 3, 0, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h45; wr_data = 8'hFF;  // commits at E+3
    @(negedge clk);
    wr_en = 1'b0;
    check_state("R10 same phase", 1'b1, 3, 0, 1'b0);
    model[5] = 8'hFF;
    @(posedge clk); @(posedge clk); @(negedge clk);  // after E+5
    check_state("R10 next phase", 1'b1, 3, 1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule